// File: doc/BRIEF.md
# Interrupt Dispatch and Halt-Wake Sequencer

This block arbitrates five interrupt sources for a small 8-bit processor core and sequences the core's low-power halt. It keeps a request register and an enable register on a byte-wide register bus. It also keeps a master interrupt enable and the halt status. Peripherals raise requests with single-cycle pulses. The core signals each instruction boundary with a strobe. At that strobe the controller decides whether to redirect execution to a restart vector instead of fetching the next opcode.

While the core is halted, the controller paces time in fixed steps of four clock cycles. It reports each idle step so the surrounding logic can advance its peripherals. At the end of every step it checks for a request that is both pending and enabled. Such a request always ends the halt, even with the master enable clear. A dispatch follows only when the master enable is set. On halt entry the controller records which of three situations applied. When a request is already pending with the master enable clear, it raises a one-cycle flag so that the core can reproduce the skipped program-counter increment. The core does not stop in that case.

Top module: `irq_sequencer`

## Requirements
- R1: After reset the request and enable registers are zero, the master enable is clear, the block is not halted, the recorded halt kind is 0, and the dispatch, vector, halt_bug and halt_step outputs are all zero.
- R2: The request register is at address 0xFF0F and the enable register at 0xFFFF. In both, bit 0 is vertical blank, bit 1 LCD status, bit 2 timer, bit 3 serial and bit 4 joypad. A read returns the register in bits 4:0 with bits 7:5 as 1, combinationally from the address. Any other address reads 0x00, and a write to it changes nothing.
- R3: A src_pulse bit sets its request bit at the next edge. The pulse wins over a same-cycle bus write or dispatch that would clear that bit.
- R4: A boundary strobe while running, with the master enable set and request AND enable nonzero, makes dispatch high for exactly the following cycle. Without the master enable, or with no qualifying source, there is no dispatch.
- R5: Only the lowest-numbered qualifying bit is taken. The vector is 0x40 + 8 × bit number and holds until the next dispatch.
- R6: At the dispatch edge the taken request bit is cleared and the other bits are kept. The clear is applied after a same-cycle bus write. The master enable is cleared whatever ime_set does.
- R7: halt_req while running is classified and accepted. With the master enable set, halt_kind becomes 1 and halted rises. Otherwise, with request AND enable nonzero, halt_kind becomes 2, halt_bug pulses for one cycle and the block keeps running. Otherwise halt_kind becomes 0 and halted rises. The kind holds until the next accepted entry.
- R8: While halted, each step lasts 4 cycles and boundary is ignored. When a step ends with request AND enable zero, halt_step pulses for one cycle. The first pulse comes 4 cycles after halted rises.
- R9: When a step ends with request AND enable nonzero, halted falls at that edge regardless of the master enable. If the master enable is set, the dispatch of R4/R5 happens at the same edge. If it is clear, there is no dispatch and the request bits are left untouched.
- R10: halt_req has no effect while halted, or in a cycle in which a dispatch is taken.
- R11: ime_set sets the master enable and ime_clr clears it, visible in the next cycle. When both are high, ime_clr wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 16 | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_wdata | input | 8 | Register bus write data |
| bus_rdata | output | 8 | Register bus read data (combinational) |
| src_pulse | input | 5 | Per-source request pulses from peripherals |
| ime_set | input | 1 | Set master enable |
| ime_clr | input | 1 | Clear master enable |
| boundary | input | 1 | Instruction boundary strobe from the core |
| halt_req | input | 1 | Core executed a halt instruction |
| dispatch | output | 1 | One-cycle interrupt dispatch strobe |
| vector | output | 8 | Restart vector of the last dispatch |
| ime | output | 1 | Master enable state |
| halted | output | 1 | Core is held in halt |
| halt_kind | output | 2 | Kind recorded at last halt entry (0 none pending, 1 enabled, 2 pending) |
| halt_bug | output | 1 | One-cycle flag for the pending-at-entry case |
| halt_step | output | 1 | One-cycle pulse per idle 4-cycle halt step |

## Verification
Several rules are checked on every cycle by the assertions. A dispatch needs a master enable that was set a cycle earlier and always leaves it cleared. The vector must lie on the restart grid. A request pulse always lands. halt_bug and halt_step are each consistent with the halt state. A halt only ends with a pending, enabled request. Other behaviour depends on a whole sequence and only the bench's scenarios can show it. That covers the priority order among several qualifying sources, the exact four-cycle pacing of halt steps, and the halt-entry classification. It also covers a wake without a dispatch that leaves the request intact, and a halt request lost to a same-cycle dispatch. A random phase compares every output against a cycle model.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Halt-entry classification recorded by the sequencer.
    typedef enum logic [1:0] {
        HK_NONE = 2'd0,   // master enable clear, nothing pending
        HK_IME  = 2'd1,   // master enable set
        HK_BUG  = 2'd2    // master enable clear, request already pending
    } halt_kind_e;

    // Restart address for source number idx.
    function automatic logic [7:0] vec_of(input logic [7:0] base,
                                          input logic [7:0] stride,
                                          input int unsigned idx);
        logic [7:0] step;
        step = 8'(idx) * stride;
        return base + step;
    endfunction

endpackage

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int unsigned N  = 5,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  pend,
    output logic          any,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);

    // Lowest index wins: walk upward and stop at the first set bit.
    always_comb begin
        logic seen;
        seen   = 1'b0;
        onehot = '0;
        idx    = '0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && !seen) begin
                onehot[i] = 1'b1;
                idx       = IW'(i);
                seen      = 1'b1;
            end
        end
        any = seen;
    end

endmodule

// File: rtl/irq_regs.sv
module irq_regs #(
    parameter int unsigned    N       = 5,
    parameter int unsigned    AW      = 16,
    parameter int unsigned    DW      = 8,
    parameter logic [AW-1:0]  REQ_ADR = 'hFF0F,
    parameter logic [AW-1:0]  ENA_ADR = 'hFFFF
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] bus_addr,
    input  logic          bus_wr,
    input  logic [DW-1:0] bus_wdata,
    output logic [DW-1:0] bus_rdata,
    input  logic [N-1:0]  src_pulse,
    input  logic [N-1:0]  take_clr,
    output logic [N-1:0]  req_q,
    output logic [N-1:0]  en_q
);

    localparam int unsigned PADW = DW - N;

    typedef struct packed {
        logic [N-1:0] req;
        logic [N-1:0] en;
    } regs_t;

    regs_t        s_d, s_q;
    logic         wr_req, wr_ena;
    logic [N-1:0] req_nx;
    logic         unused_hi;

    assign wr_req    = bus_wr && (bus_addr == REQ_ADR);
    assign wr_ena    = bus_wr && (bus_addr == ENA_ADR);
    assign unused_hi = ^bus_wdata[DW-1:N];

    // Per-bit next request: written or held value, dispatch clear, then pulse set.
    for (genvar b = 0; b < N; b++) begin : g_bit
        assign req_nx[b] = src_pulse[b]
                         | (~take_clr[b] & (wr_req ? bus_wdata[b] : s_q.req[b]));

        p_pulse_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
            src_pulse[b] |=> req_q[b]);
        p_dispatch_clears_bit_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (take_clr[b] && !src_pulse[b]) |=> !req_q[b]);
    end

    always_comb begin
        s_d     = s_q;
        s_d.req = req_nx;
        if (wr_ena) s_d.en = bus_wdata[N-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        if (bus_addr == REQ_ADR)      bus_rdata = {{PADW{1'b1}}, s_q.req};
        else if (bus_addr == ENA_ADR) bus_rdata = {{PADW{1'b1}}, s_q.en};
        else                          bus_rdata = '0;
    end

    assign req_q = s_q.req;
    assign en_q  = s_q.en;

    p_en_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ena |=> $stable(en_q));

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int unsigned N          = 5,
    parameter int unsigned HALT_CYC   = 4,
    parameter logic [7:0]  VEC_BASE   = 8'h40,
    parameter logic [7:0]  VEC_STRIDE = 8'h08,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned CW = (HALT_CYC > 1) ? $clog2(HALT_CYC) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          boundary,
    input  logic          halt_req,
    input  logic          ime_set,
    input  logic          ime_clr,
    input  logic          pend_any,
    input  logic [IW-1:0] pend_idx,
    output logic          take,
    output logic          ime_q,
    output logic          halted_q,
    output logic [1:0]    halt_kind_q,
    output logic          halt_bug_q,
    output logic          halt_step_q,
    output logic          dispatch_q,
    output logic [7:0]    vector_q
);

    typedef struct packed {
        logic         ime;
        logic         halted;
        halt_kind_e   kind;
        logic         bug;
        logic         step;
        logic         disp;
        logic [7:0]   vec;
        logic [CW-1:0] cnt;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic  last, eval, entry;

    always_comb begin
        s_d      = s_q;
        s_d.bug  = 1'b0;
        s_d.step = 1'b0;

        last  = (s_q.cnt == CW'(HALT_CYC - 1));
        eval  = s_q.halted ? last : boundary;
        take  = eval && s_q.ime && pend_any;
        entry = halt_req && !s_q.halted && !take;

        s_d.disp = take;
        if (take) s_d.vec = vec_of(VEC_BASE, VEC_STRIDE, int'(pend_idx));

        if (s_q.halted) begin
            s_d.cnt = last ? '0 : s_q.cnt + 1'b1;
            if (last) begin
                if (pend_any) s_d.halted = 1'b0;
                else          s_d.step   = 1'b1;
            end
        end else begin
            s_d.cnt = '0;
            if (entry) begin
                if (s_q.ime) begin
                    s_d.kind   = HK_IME;
                    s_d.halted = 1'b1;
                end else if (pend_any) begin
                    s_d.kind = HK_BUG;
                    s_d.bug  = 1'b1;
                end else begin
                    s_d.kind   = HK_NONE;
                    s_d.halted = 1'b1;
                end
            end
        end

        if (take)         s_d.ime = 1'b0;
        else if (ime_clr) s_d.ime = 1'b0;
        else if (ime_set) s_d.ime = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.kind <= HK_NONE;
        end else begin
            s_q <= s_d;
        end
    end

    assign ime_q       = s_q.ime;
    assign halted_q    = s_q.halted;
    assign halt_kind_q = s_q.kind;
    assign halt_bug_q  = s_q.bug;
    assign halt_step_q = s_q.step;
    assign dispatch_q  = s_q.disp;
    assign vector_q    = s_q.vec;

    p_disp_needs_ime_r4: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_q |-> $past(ime_q));
    p_disp_clears_ime_r6: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_q |-> !ime_q);
    p_vector_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        dispatch_q |-> (int'(vector_q) >= int'(VEC_BASE)
                        && int'(vector_q) < int'(VEC_BASE) + int'(N) * int'(VEC_STRIDE)
                        && ((int'(vector_q) - int'(VEC_BASE)) % int'(VEC_STRIDE)) == 0));
    p_bug_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
        halt_bug_q |-> !halted_q);
    p_wake_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(halted_q) |-> $past(pend_any));
    p_step_halted_r8: assert property (@(posedge clk) disable iff (!rst_n)
        halt_step_q |-> halted_q);
    p_clr_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ime_clr |=> !ime_q);

endmodule

// File: rtl/irq_sequencer.sv
module irq_sequencer #(
    parameter int unsigned   N_SRC      = 5,
    parameter int unsigned   AW         = 16,
    parameter int unsigned   DW         = 8,
    parameter logic [AW-1:0] REQ_ADR    = 'hFF0F,
    parameter logic [AW-1:0] ENA_ADR    = 'hFFFF,
    parameter int unsigned   HALT_CYC   = 4,
    parameter logic [7:0]    VEC_BASE   = 8'h40,
    parameter logic [7:0]    VEC_STRIDE = 8'h08
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    bus_addr,
    input  logic             bus_wr,
    input  logic [DW-1:0]    bus_wdata,
    output logic [DW-1:0]    bus_rdata,
    input  logic [N_SRC-1:0] src_pulse,
    input  logic             ime_set,
    input  logic             ime_clr,
    input  logic             boundary,
    input  logic             halt_req,
    output logic             dispatch,
    output logic [7:0]       vector,
    output logic             ime,
    output logic             halted,
    output logic [1:0]       halt_kind,
    output logic             halt_bug,
    output logic             halt_step
);

    localparam int unsigned IW = (N_SRC > 1) ? $clog2(N_SRC) : 1;

    logic [N_SRC-1:0] req_q, en_q, pend, onehot, take_clr;
    logic             pend_any, take;
    logic [IW-1:0]    pend_idx;

    assign pend     = req_q & en_q;
    assign take_clr = take ? onehot : '0;

    irq_regs #(
        .N(N_SRC), .AW(AW), .DW(DW), .REQ_ADR(REQ_ADR), .ENA_ADR(ENA_ADR)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .src_pulse(src_pulse), .take_clr(take_clr),
        .req_q(req_q), .en_q(en_q)
    );

    irq_prio #(.N(N_SRC)) u_prio (
        .pend(pend), .any(pend_any), .onehot(onehot), .idx(pend_idx)
    );

    irq_ctrl #(
        .N(N_SRC), .HALT_CYC(HALT_CYC), .VEC_BASE(VEC_BASE), .VEC_STRIDE(VEC_STRIDE)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .boundary(boundary), .halt_req(halt_req),
        .ime_set(ime_set), .ime_clr(ime_clr),
        .pend_any(pend_any), .pend_idx(pend_idx),
        .take(take),
        .ime_q(ime), .halted_q(halted), .halt_kind_q(halt_kind),
        .halt_bug_q(halt_bug), .halt_step_q(halt_step),
        .dispatch_q(dispatch), .vector_q(vector)
    );

endmodule

// File: tb/irq_sequencer_tb.sv
module irq_sequencer_tb;

    localparam logic [15:0] A_REQ = 16'hFF0F;
    localparam logic [15:0] A_ENA = 16'hFFFF;
    localparam logic [15:0] A_OTH = 16'hFF10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [4:0]  src_pulse = '0;
    logic        ime_set = 1'b0, ime_clr = 1'b0, boundary = 1'b0, halt_req = 1'b0;
    logic        dispatch, ime, halted, halt_bug, halt_step;
    logic [7:0]  vector;
    logic [1:0]  halt_kind;

    int tests = 0;
    int fails = 0;
    int wd    = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    irq_sequencer u_dut (
        .clk(clk), .rst_n(rst_n),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .src_pulse(src_pulse), .ime_set(ime_set), .ime_clr(ime_clr),
        .boundary(boundary), .halt_req(halt_req),
        .dispatch(dispatch), .vector(vector), .ime(ime), .halted(halted),
        .halt_kind(halt_kind), .halt_bug(halt_bug), .halt_step(halt_step)
    );

    // ---------------- reference cycle model ----------------
    logic [4:0] m_req, m_en;
    logic       m_ime, m_halted, m_bug, m_step, m_disp;
    logic [1:0] m_kind, m_cnt;
    logic [7:0] m_vec;

    function automatic int first_bit(input logic [4:0] v);
        for (int i = 0; i < 5; i++) if (v[i]) return i;
        return 0;
    endfunction

    function automatic logic [7:0] exp_rdata(input logic [15:0] a);
        if (a == A_REQ) return {3'b111, m_req};
        if (a == A_ENA) return {3'b111, m_en};
        return 8'h00;
    endfunction

    always @(posedge clk) begin : model
        logic [4:0] pend, base;
        logic       any, last, ev, tk;
        int         sel;
        if (!rst_n) begin
            m_req <= '0; m_en <= '0; m_ime <= 1'b0; m_halted <= 1'b0; m_bug <= 1'b0;
            m_step <= 1'b0; m_disp <= 1'b0; m_kind <= 2'd0; m_cnt <= 2'd0; m_vec <= 8'h00;
        end else begin
            pend = m_req & m_en;
            any  = |pend;
            sel  = first_bit(pend);
            last = (m_cnt == 2'd3);
            ev   = m_halted ? last : boundary;
            tk   = ev && m_ime && any;
            base = (bus_wr && bus_addr == A_REQ) ? bus_wdata[4:0] : m_req;
            if (tk) base[sel] = 1'b0;
            m_req <= base | src_pulse;
            if (bus_wr && bus_addr == A_ENA) m_en <= bus_wdata[4:0];
            m_disp <= tk;
            if (tk) m_vec <= 8'h40 + 8'(sel * 8);
            m_bug  <= 1'b0;
            m_step <= 1'b0;
            if (m_halted) begin
                m_cnt <= last ? 2'd0 : m_cnt + 2'd1;
                if (last) begin
                    if (any) m_halted <= 1'b0;
                    else     m_step   <= 1'b1;
                end
            end else begin
                m_cnt <= 2'd0;
                if (halt_req && !tk) begin
                    if (m_ime)    begin m_kind <= 2'd1; m_halted <= 1'b1; end
                    else if (any) begin m_kind <= 2'd2; m_bug <= 1'b1; end
                    else          begin m_kind <= 2'd0; m_halted <= 1'b1; end
                end
            end
            m_ime <= tk ? 1'b0 : (ime_clr ? 1'b0 : (ime_set ? 1'b1 : m_ime));
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd == 100000) begin
            tests++;
            fails++;
            $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", wd);
            summary();
        end
    end

    task automatic idle();
        bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0; src_pulse = '0;
        ime_set = 1'b0; ime_clr = 1'b0; boundary = 1'b0; halt_req = 1'b0;
    endtask

    task automatic tick();
        @(negedge clk);
        idle();
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
    endtask

    task automatic rd_chk(input string tag, input logic [15:0] a, input logic [7:0] exp);
        bus_addr = a;
        #1;
        chk(tag, 32'(bus_rdata), 32'(exp));
        bus_addr = '0;
    endtask

    task automatic wait_wake();
        for (int k = 0; k < 8 && halted; k++) tick();
    endtask

    // ---------------- stimulus ----------------
    initial begin
        void'($urandom(32'd20240611));
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk("R1 ime", 32'(ime), 0);
        chk("R1 halted", 32'(halted), 0);
        chk("R1 dispatch", 32'(dispatch), 0);
        chk("R1 vector", 32'(vector), 0);
        chk("R1 kind", 32'(halt_kind), 0);
        chk("R1 halt_bug/step", 32'({halt_bug, halt_step}), 0);
        rd_chk("R1 req read", A_REQ, 8'hE0);
        rd_chk("R1 ena read", A_ENA, 8'hE0);

        // R2: register bus
        wr(A_ENA, 8'h1F);
        wr(A_REQ, 8'h03);
        rd_chk("R2 req read", A_REQ, 8'hE3);
        rd_chk("R2 ena read", A_ENA, 8'hFF);
        wr(A_OTH, 8'h55);
        rd_chk("R2 other addr read", A_OTH, 8'h00);
        rd_chk("R2 other write ignored", A_REQ, 8'hE3);

        // R11: master enable control
        ime_set = 1'b1; tick();
        chk("R11 set", 32'(ime), 1);
        ime_set = 1'b1; ime_clr = 1'b1; tick();
        chk("R11 clear wins", 32'(ime), 0);

        // R4: no dispatch without master enable
        boundary = 1'b1; tick();
        chk("R4 no ime no dispatch", 32'(dispatch), 0);
        ime_set = 1'b1; tick();
        boundary = 1'b1; tick();
        chk("R4 dispatch", 32'(dispatch), 1);
        chk("R5 vblank vector", 32'(vector), 32'h40);
        chk("R6 ime cleared", 32'(ime), 0);
        rd_chk("R6 taken bit cleared", A_REQ, 8'hE2);
        tick();
        chk("R4 one-cycle strobe", 32'(dispatch), 0);
        chk("R5 vector held", 32'(vector), 32'h40);
        ime_set = 1'b1; tick();
        boundary = 1'b1; tick();
        chk("R5 lcd vector", 32'(vector), 32'h48);
        rd_chk("R6 req after second", A_REQ, 8'hE0);

        // R5: enable mask picks serial over lower pending bits
        wr(A_ENA, 8'h18);
        wr(A_REQ, 8'h1F);
        ime_set = 1'b1; tick();
        boundary = 1'b1; tick();
        chk("R5 masked priority", 32'(vector), 32'h58);
        rd_chk("R6 others kept", A_REQ, 8'hF7);

        // R3: pulse beats write clear
        bus_wr = 1'b1; bus_addr = A_REQ; bus_wdata = 8'h00; src_pulse = 5'b00100; tick();
        rd_chk("R3 pulse wins", A_REQ, 8'hE4);

        // R7: pending kind
        wr(A_REQ, 8'h10);
        halt_req = 1'b1; tick();
        chk("R7 bug flag", 32'(halt_bug), 1);
        chk("R7 bug not halted", 32'(halted), 0);
        chk("R7 bug kind", 32'(halt_kind), 2);
        tick();
        chk("R7 bug one cycle", 32'(halt_bug), 0);

        // R7/R8: none-pending kind and step pacing
        wr(A_REQ, 8'h00);
        halt_req = 1'b1; tick();
        chk("R7 none halted", 32'(halted), 1);
        chk("R7 none kind", 32'(halt_kind), 0);
        for (int k = 1; k <= 3; k++) begin
            tick();
            chk("R8 no early step", 32'(halt_step), 0);
        end
        tick();
        chk("R8 step pulse", 32'(halt_step), 1);
        boundary = 1'b1; tick();
        chk("R8 step one cycle", 32'(halt_step), 0);
        chk("R8 boundary ignored", 32'(dispatch), 0);

        // R10: halt_req while halted changes nothing
        ime_set = 1'b1; tick();
        halt_req = 1'b1; tick();
        chk("R10 kind kept", 32'(halt_kind), 0);
        chk("R10 still halted", 32'(halted), 1);

        // R9: wake with dispatch
        src_pulse = 5'b01000; tick();
        wait_wake();
        chk("R9 woke", 32'(halted), 0);
        chk("R9 wake dispatch", 32'(dispatch), 1);
        chk("R9 wake vector", 32'(vector), 32'h58);

        // R9: wake without master enable
        tick();
        halt_req = 1'b1; tick();
        chk("R9 halted again", 32'(halted), 1);
        src_pulse = 5'b10000; tick();
        wait_wake();
        chk("R9 woke no ime", 32'(halted), 0);
        chk("R9 no dispatch", 32'(dispatch), 0);
        rd_chk("R9 request kept", A_REQ, 8'hF0);

        // R7: enabled kind, then wake only once enabled
        wr(A_REQ, 8'h00);
        ime_set = 1'b1; tick();
        halt_req = 1'b1; tick();
        chk("R7 enabled kind", 32'(halt_kind), 1);
        chk("R7 enabled halted", 32'(halted), 1);
        src_pulse = 5'b00001; tick();
        repeat (8) tick();
        chk("R9 masked no wake", 32'(halted), 1);
        wr(A_ENA, 8'h1F);
        wait_wake();
        chk("R9 vblank wake dispatch", 32'(dispatch), 1);
        chk("R9 vblank wake vector", 32'(vector), 32'h40);

        // R10: dispatch beats halt_req
        tick();
        wr(A_REQ, 8'h02);
        ime_set = 1'b1; tick();
        boundary = 1'b1; halt_req = 1'b1; tick();
        chk("R10 dispatch taken", 32'(dispatch), 1);
        chk("R10 vector", 32'(vector), 32'h48);
        chk("R10 not halted", 32'(halted), 0);
        chk("R10 no bug", 32'(halt_bug), 0);

        // Random phase against the cycle model
        for (int i = 0; i < 3000; i++) begin
            int r;
            r         = int'($urandom % 3);
            bus_addr  = (r == 0) ? A_REQ : (r == 1) ? A_ENA : A_OTH;
            bus_wr    = ($urandom % 6) == 0;
            bus_wdata = 8'($urandom);
            for (int b = 0; b < 5; b++) src_pulse[b] = ($urandom % 16) == 0;
            ime_set   = ($urandom % 10) == 0;
            ime_clr   = ($urandom % 20) == 0;
            boundary  = ($urandom % 4) == 0;
            halt_req  = ($urandom % 40) == 0;
            #1;
            chk("R2 random read", 32'(bus_rdata), 32'(exp_rdata(bus_addr)));
            @(negedge clk);
            chk("R4 random dispatch", 32'(dispatch), 32'(m_disp));
            chk("R5 random vector", 32'(vector), 32'(m_vec));
            chk("R11 random ime", 32'(ime), 32'(m_ime));
            chk("R7 random halted/kind/bug", 32'({halted, halt_kind, halt_bug}),
                32'({m_halted, m_kind, m_bug}));
            chk("R8 random step", 32'(halt_step), 32'(m_step));
        end
        idle();

        summary();
    end

endmodule